// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds the current time and date as seven packed-BCD registers: seconds, minutes, hours, day of month, month, two-digit year and a three-bit weekday counter. A free-running time-base pulse drives it. A small prescaler counts `TICKS_PER_SEC` of those pulses to make one second. At each second the fields advance with full carry propagation, so a single second can roll every field at once.

The hour register serves both hour formats. Bit 6 selects 24-hour counting when set. In 12-hour counting, bit 5 is the afternoon flag and bits 4:0 hold the BCD hour. In 24-hour counting, bits 5:0 hold the BCD hour. Day-of-month follows the length of each month. February gains its 29th day whenever the two-digit year is a multiple of four, and year 00 counts as one of those years.

Software loads any single field through a one-cycle write strobe with a 3-bit field selector. A write also restarts the sub-second prescaler, so the next second elapses a full `TICKS_PER_SEC` pulses after the write.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD. Seconds wrap from 59 to 00 and advance minutes by one. Minutes wrap from 59 to 00 and advance the hour.
- R2: The counter advances by one second on the `TICKS_PER_SEC`-th `tick_i` pulse that follows reset or the last write. Pulses before that one leave every output unchanged.
- R3: When hour bit 6 is 1 (24-hour mode), bits 5:0 count BCD 00 to 23. The step from 23 to 00 advances the date and the weekday.
- R4: When hour bit 6 is 0 (12-hour mode), bits 4:0 step 12, 01, 02, … 11 and back to 12. Bit 5 (1 = PM) inverts on the step from 11 to 12. Date and weekday advance only on the step from 11 PM to 12 AM.
- R5: April, June, September and November end after day 30. January, March, May, July, August, October and December end after day 31. The day after the last one is 01 of the next month.
- R6: February ends after day 29 when the BCD year is a multiple of four (00, 04, … 96). In all other years it ends after day 28.
- R7: Month counts 01 to 12, and the step from 12 to 01 advances the year. Year counts 00 to 99 and wraps to 00.
- R8: The weekday counts 0 to 6, wraps to 0, and advances together with the date.
- R9: While `wr_en_i` is high, the field chosen by `wr_sel_i` (0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 weekday) takes `wr_data_i` at the next clock edge. The prescaler restarts, and a `tick_i` pulse in that same cycle is discarded.
- R10: After reset the fields read seconds 00, minutes 00, hour 0x12 (12-hour mode, AM, 12 o'clock), date 01, month 01, year 00, weekday 0.
- R11: A single second carries through every field: 23:59:59 on day 31 of month 12 of year 99 becomes 00:00:00 on 01/01/00, with the weekday stepping forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base pulse, one cycle wide |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field selector for the write |
| wr_data_i | input | 8 | BCD value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour with mode bit 6 and PM bit 5 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| dow_o | output | 3 | Day of week, 0 to 6 |

## Verification
A write is visible one clock edge after the cycle in which `wr_en_i` is high. A counted second, including the whole carry chain through date, month, year and weekday, appears on the same edge that samples the final prescaler pulse. The bench drives every input on the falling edge and reads outputs on the falling edge after the edge concerned, so each check lands exactly one register stage after its stimulus. Prescaler checks also sample one pulse early, to confirm that nothing moved before the second was due.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int FIELD_W = 8;
  localparam int DOW_W   = 3;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5,
    FLD_DOW   = 3'd6
  } field_e;

  // Two-digit BCD increment; the caller handles the wrap limit.
  function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
    logic [FIELD_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // (10*t + u) mod 4 == (2*t + u) mod 4, which only needs t[0] and u[1:0].
  function automatic logic year_is_leap(input logic [FIELD_W-1:0] y);
    logic [1:0] m;
    m = {y[4], 1'b0} + y[1:0];
    return (m == 2'd0);
  endfunction

  function automatic logic [FIELD_W-1:0] month_last_day(input logic [FIELD_W-1:0] mo,
                                                        input logic leap);
    logic [FIELD_W-1:0] d;
    unique case (mo)
      8'h02:                      d = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic sec_stb_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign sec_stb_o = tick_i && at_last && !restart_i;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (tick_i) cnt_d = at_last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
  import rtc_cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RST_VAL = '0,
  parameter logic [FIELD_W-1:0] LO_VAL  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  input  logic               ld_i,
  input  logic [FIELD_W-1:0] ld_val_i,
  input  logic [FIELD_W-1:0] hi_i,
  output logic [FIELD_W-1:0] val_o,
  output logic               wrap_o
);
  logic [FIELD_W-1:0] val_q, val_d;
  logic               at_top;

  assign at_top = (val_q >= hi_i);
  assign wrap_o = inc_i && !ld_i && at_top;
  assign val_o  = val_q;

  always_comb begin
    val_d = val_q;
    if (ld_i)       val_d = ld_val_i;
    else if (inc_i) val_d = at_top ? LO_VAL : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RST_VAL;
    else        val_q <= val_d;
  end
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
  import rtc_cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  input  logic               ld_i,
  input  logic [FIELD_W-1:0] ld_val_i,
  output logic [FIELD_W-1:0] hour_o,
  output logic               day_o
);
  localparam logic [FIELD_W-1:0] RST_HOUR = 8'h12;

  logic [FIELD_W-1:0] q, d;
  logic [FIELD_W-1:0] h24, h12, inc24, inc12;
  logic               mode24, pm;

  assign mode24 = q[6];
  assign pm     = q[5];
  assign h24    = {2'b00, q[5:0]};
  assign h12    = {3'b000, q[4:0]};
  assign inc24  = bcd_inc(h24);
  assign inc12  = bcd_inc(h12);
  assign hour_o = q;

  always_comb begin
    d     = q;
    day_o = 1'b0;
    if (ld_i) begin
      d = ld_val_i;
    end else if (inc_i) begin
      if (mode24) begin
        if (h24 >= 8'h23) begin
          d     = 8'h40;
          day_o = 1'b1;
        end else begin
          d = {2'b01, inc24[5:0]};
        end
      end else begin
        if (h12 >= 8'h12) begin
          d = {2'b00, pm, 5'h01};
        end else if (h12 == 8'h11) begin
          d     = {2'b00, ~pm, 5'h12};
          day_o = pm;
        end else begin
          d = {2'b00, pm, inc12[4:0]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_HOUR;
    else        q <= d;
  end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  output logic [FIELD_W-1:0] sec_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] date_o,
  output logic [FIELD_W-1:0] month_o,
  output logic [FIELD_W-1:0] year_o,
  output logic [DOW_W-1:0]   dow_o
);
  localparam int NUM_WRAP = 5;  // sec, min, date, month, year

  logic                 sec_stb;
  logic                 day_stb;
  logic [NUM_WRAP-1:0]  ld, wrap, inc;
  logic [FIELD_W-1:0]   hi   [NUM_WRAP];
  logic [FIELD_W-1:0]   val  [NUM_WRAP];
  logic [FIELD_W-1:0]   mask [NUM_WRAP];
  logic                 ld_hour, ld_dow;
  logic [DOW_W-1:0]     dow_q, dow_d;

  rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .restart_i (wr_en_i),
    .sec_stb_o (sec_stb)
  );

  // Slot 0 sec, 1 min, 2 date, 3 month, 4 year.
  assign ld[0]   = wr_en_i && (wr_sel_i == FLD_SEC);
  assign ld[1]   = wr_en_i && (wr_sel_i == FLD_MIN);
  assign ld[2]   = wr_en_i && (wr_sel_i == FLD_DATE);
  assign ld[3]   = wr_en_i && (wr_sel_i == FLD_MONTH);
  assign ld[4]   = wr_en_i && (wr_sel_i == FLD_YEAR);
  assign ld_hour = wr_en_i && (wr_sel_i == FLD_HOUR);
  assign ld_dow  = wr_en_i && (wr_sel_i == FLD_DOW);

  // Carry chain: seconds -> minutes -> hours -> date -> month -> year.
  assign inc[0] = sec_stb;
  assign inc[1] = wrap[0];
  assign inc[2] = day_stb;
  assign inc[3] = wrap[2];
  assign inc[4] = wrap[3];

  assign hi[0] = 8'h59;
  assign hi[1] = 8'h59;
  assign hi[2] = month_last_day(val[3], year_is_leap(val[4]));
  assign hi[3] = 8'h12;
  assign hi[4] = 8'h99;

  assign mask[0] = 8'h7F;
  assign mask[1] = 8'h7F;
  assign mask[2] = 8'h3F;
  assign mask[3] = 8'h1F;
  assign mask[4] = 8'hFF;

  generate
    for (genvar i = 0; i < NUM_WRAP; i++) begin : g_field
      localparam logic [FIELD_W-1:0] BASE = (i == 2 || i == 3) ? 8'h01 : 8'h00;
      rtc_bcd_wrap #(.RST_VAL(BASE), .LO_VAL(BASE)) u_fld (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (inc[i]),
        .ld_i     (ld[i]),
        .ld_val_i (wr_data_i & mask[i]),
        .hi_i     (hi[i]),
        .val_o    (val[i]),
        .wrap_o   (wrap[i])
      );
    end
  endgenerate

  rtc_hour_ctr u_hour (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_i    (wrap[1]),
    .ld_i     (ld_hour),
    .ld_val_i (wr_data_i & 8'h7F),
    .hour_o   (hour_o),
    .day_o    (day_stb)
  );

  always_comb begin
    dow_d = dow_q;
    if (ld_dow)       dow_d = wr_data_i[DOW_W-1:0];
    else if (day_stb) dow_d = (dow_q >= 3'd6) ? 3'd0 : dow_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dow_q <= '0;
    else        dow_q <= dow_d;
  end

  assign sec_o   = val[0];
  assign min_o   = val[1];
  assign date_o  = val[2];
  assign month_o = val[3];
  assign year_o  = val[4];
  assign dow_o   = dow_q;
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic [2:0] dow_o
);
  // R2: no pulse and no write means nothing moves.
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(date_o) && $stable(month_o) && $stable(year_o) && $stable(dow_o)));

  // R9: a seconds write shows up on the next edge.
  p_sec_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd0) |=> (sec_o == ($past(wr_data_i) & 8'h7F)));

  // R1: minutes move only when seconds sit at 59.
  p_min_ripple_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && sec_o != 8'h59) |=> $stable(min_o));

  // R1: from 59, seconds stay or go to 00.
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && sec_o == 8'h59) |=> (sec_o == 8'h59 || sec_o == 8'h00));

  // R3: the format bit changes only through a write.
  p_mode_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(hour_o[6]));

  // R8: the weekday only holds or steps by one below 6.
  p_dow_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && dow_o < 3'd6) |=> (dow_o == $past(dow_o) || dow_o == $past(dow_o) + 3'd1));

  // R7: the year only moves when the month is 12.
  p_year_ripple_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && month_o != 8'h12) |=> $stable(year_o));
endmodule

bind rtc_bcd_calendar rtc_calendar_checker u_chk (.*);

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;
  localparam int TPS  = 4;
  localparam int NVEC = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] dow_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_calendar #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .date_o(date_o), .month_o(month_o), .year_o(year_o), .dow_o(dow_o)
  );

  // Byte order: sec, min, hour, date, month, year, dow.
  localparam logic [55:0] PRE [NVEC] = '{
    56'h00_00_12_01_01_00_00,  // R1 plain step
    56'h59_00_12_01_01_00_00,  // R1 sec wrap
    56'h59_59_47_01_01_00_00,  // R1 min wrap, 24h hour step
    56'h59_59_50_01_01_00_00,  // R3 09->10 style (10->11)
    56'h59_59_63_15_06_10_02,  // R3 R8 23->00
    56'h59_59_11_10_03_10_01,  // R4 11 AM -> 12 PM
    56'h59_59_32_10_03_10_01,  // R4 12 PM -> 01 PM
    56'h59_59_31_10_03_10_01,  // R4 11 PM -> 12 AM, day steps
    56'h59_59_63_30_04_10_03,  // R5 April ends at 30
    56'h59_59_63_30_01_10_03,  // R5 January day 31 exists
    56'h59_59_63_30_11_45_03,  // R5 November ends at 30
    56'h59_59_63_28_02_23_03,  // R6 non-leap
    56'h59_59_63_28_02_24_03,  // R6 leap
    56'h59_59_63_29_02_00_03,  // R6 year 00 leap, ends 29
    56'h59_59_63_28_02_16_03,  // R6 odd tens leap
    56'h59_59_63_28_02_18_03,  // R6 odd tens non-leap
    56'h59_59_63_31_12_99_06   // R11 R7 R8 full ripple
  };
  localparam logic [55:0] EXP [NVEC] = '{
    56'h01_00_12_01_01_00_00,
    56'h00_01_12_01_01_00_00,
    56'h00_00_48_01_01_00_00,
    56'h00_00_51_01_01_00_00,
    56'h00_00_40_16_06_10_03,
    56'h00_00_32_10_03_10_01,
    56'h00_00_21_10_03_10_01,
    56'h00_00_12_11_03_10_02,
    56'h00_00_40_01_05_10_04,
    56'h00_00_40_31_01_10_04,
    56'h00_00_40_01_12_45_04,
    56'h00_00_40_01_03_23_04,
    56'h00_00_40_29_02_24_04,
    56'h00_00_40_01_03_00_04,
    56'h00_00_40_29_02_16_04,
    56'h00_00_40_01_03_18_04,
    56'h00_00_40_01_01_00_00
  };
  localparam string TAG [NVEC] = '{
    "R1", "R1", "R1", "R3", "R3 R8", "R4", "R4", "R4 R8", "R5", "R5", "R5",
    "R6", "R6", "R6", "R6", "R6", "R11 R7 R8"
  };

  function automatic logic [55:0] snap();
    return {sec_o, min_o, hour_o, date_o, month_o, year_o, 5'd0, dow_o};
  endfunction

  task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic load_all(input logic [55:0] v);
    wr(3'd0, v[55:48]); wr(3'd1, v[47:40]); wr(3'd2, v[39:32]);
    wr(3'd3, v[31:24]); wr(3'd4, v[23:16]); wr(3'd5, v[15:8]);
    wr(3'd6, v[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset values.
    check("R10", snap(), 56'h00_00_12_01_01_00_00);

    // R2 prescaler: one early pulse short changes nothing.
    pulses(TPS - 1);
    check("R2 early", snap(), 56'h00_00_12_01_01_00_00);
    pulses(1);
    check("R2 due", snap(), 56'h01_00_12_01_01_00_00);

    for (int i = 0; i < NVEC; i++) begin
      load_all(PRE[i]);
      check("R9 load", snap(), PRE[i]);
      pulses(TPS);
      check(TAG[i], snap(), EXP[i]);
    end

    // R9: write restarts the prescaler and swallows a same-cycle pulse.
    load_all(56'h10_00_12_01_01_00_00);
    pulses(TPS - 1);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 3'd1; wr_data_i = 8'h05; tick_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    check("R9 same-cycle", snap(), 56'h10_05_12_01_01_00_00);
    pulses(TPS - 1);
    check("R9 restart", snap(), 56'h10_05_12_01_01_00_00);
    pulses(1);
    check("R9 after restart", snap(), 56'h11_05_12_01_01_00_00);

    // R8: weekday 6 wraps to 0 on a 12h PM->AM day change.
    load_all(56'h59_59_31_05_07_20_06);
    pulses(TPS);
    check("R8 wrap", snap(), 56'h00_00_12_06_07_20_00);

    // R7: month 12 of year 42 rolls to year 43.
    load_all(56'h59_59_63_31_12_42_02);
    pulses(TPS);
    check("R7 year step", snap(), 56'h00_00_40_01_01_43_03);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule